// File: doc/BRIEF.md
# Trace Port Frame Clock Generator

This block sets the pace of an off-chip trace port. It counts CPU clock cycles to mark out trace frames, and on the first cycle of each frame it raises a one-cycle strobe that tells the packer to present the next data word. It also draws the waveform of the trace output clock, which an external probe uses to capture that data. Three configuration inputs control it: a slow-rate enable, a 4-bit divisor and a select between single-edge and dual-edge capture.

The clock waveform is given at half-CPU-cycle resolution as two bits per CPU cycle. The early bit is the level during the first half of the cycle and the late bit is the level during the second half. A double-rate output register placed next to the pad turns this pair into the pin waveform. With half-cycle resolution the capture edge can land exactly at the middle of every frame, odd periods included, and the output clock keeps a 50 percent duty cycle for every divisor.

The configuration inputs are sampled only on the last cycle of a frame, so a new setting always begins with a complete frame.

Top module: `tfclk_gen`

## Requirements
- R1: While reset is held, and on the first cycle after it, frame_en_o is 1, tclk_early_o is 0 and tclk_late_o is 1. This is the full-rate, single-edge pattern.
- R2: With cfg_slow_i at 0, frame_en_o is 1 on every CPU cycle whatever cfg_div_i holds.
- R3: With cfg_slow_i at 1 and cfg_div_i = N, where N is at least 1, frame_en_o pulses for one cycle once every N+1 CPU cycles.
- R4: With cfg_slow_i at 1 and cfg_div_i at 0, frame_en_o pulses once every 2 CPU cycles.
- R5: In single-edge mode (cfg_ddr_i at 0), for a frame of P cycles with half-cycle slots h = 0 to 2P-1 (early half of cycle k is h = 2k, late half is h = 2k+1), the clock is 0 for h < P and 1 for h >= P. Its single rising edge therefore sits at the frame midpoint and the duty cycle is 50 percent.
- R6: In dual-edge mode (cfg_ddr_i at 1), the clock holds the level it started the frame with for h < P and the inverse for h >= P. The level at the start of successive frames alternates, so the clock period is two frames and each frame has exactly one edge, at its midpoint.
- R7: A change to any configuration input during a frame does not alter that frame. The value present on the last cycle of a frame sets the length and waveform of the next frame.
- R8: At the start of every dual-edge frame, the early bit equals the late bit of the cycle before it, so entering or running in dual-edge mode adds no edge at a frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_slow_i | input | 1 | Slow-rate enable; 0 gives one frame per CPU cycle |
| cfg_div_i | input | DIV_W (4) | Frame divisor, used only when cfg_slow_i is 1 |
| cfg_ddr_i | input | 1 | 1 selects dual-edge capture, 0 selects single-edge capture |
| frame_en_o | output | 1 | One-cycle strobe on the first CPU cycle of each frame |
| tclk_early_o | output | 1 | Output clock level during the first half of the current CPU cycle |
| tclk_late_o | output | 1 | Output clock level during the second half of the current CPU cycle |

## Verification
A cycle counter that drifts shows at the ports as wrong spacing between frame_en_o pulses, and a clock edge moved off the midpoint shows as a wrong early or late bit. Both appear within the first frame after the fault, which is at most 16 CPU cycles. A stale or wrongly updated level register in dual-edge mode appears at the next frame boundary: the early bit no longer matches the late bit of the cycle before, or two frames in a row start at the same level. A configuration taken up too early changes the frame that is already running, so the next strobe arrives at the wrong cycle, and the mid-frame change scenarios watch for exactly that.

// File: rtl/tfclk_pkg.sv
package tfclk_pkg;

    // Capture style of the trace output clock.
    typedef enum logic {
        EDGE_SINGLE = 1'b0,
        EDGE_DUAL   = 1'b1
    } edge_mode_e;

    // Frame length used when slow rate is on and the divisor is zero.
    localparam int unsigned ZERO_DIV_PERIOD = 2;

endpackage

// File: rtl/tfclk_cfg_hold.sv
module tfclk_cfg_hold
    import tfclk_pkg::*;
#(
    parameter int unsigned DIV_W = 4,
    localparam int unsigned PER_W = DIV_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             slow_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             ddr_i,
    input  logic             load_i,
    output logic             slow_o,
    output logic [DIV_W-1:0] div_o,
    output edge_mode_e       mode_o,
    output logic [PER_W-1:0] period_o
);

    typedef struct packed {
        logic             slow;
        logic [DIV_W-1:0] div;
        edge_mode_e       mode;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    // Next-state: take new settings only on the last cycle of a frame.
    always_comb begin
        cfg_d = cfg_q;
        if (load_i) begin
            cfg_d.slow = slow_i;
            cfg_d.div  = div_i;
            cfg_d.mode = edge_mode_e'(ddr_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '{slow: 1'b0, div: '0, mode: EDGE_SINGLE};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // Frame length in CPU cycles for the held settings.
    always_comb begin
        if (!cfg_q.slow) begin
            period_o = PER_W'(1);
        end else if (cfg_q.div == '0) begin
            period_o = PER_W'(ZERO_DIV_PERIOD);
        end else begin
            period_o = {1'b0, cfg_q.div} + PER_W'(1);
        end
    end

    assign slow_o = cfg_q.slow;
    assign div_o  = cfg_q.div;
    assign mode_o = cfg_q.mode;

    AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(cfg_q)) else $error("settings changed inside a frame"); // R7

endmodule

// File: rtl/tfclk_frame_cnt.sv
module tfclk_frame_cnt #(
    parameter int unsigned DIV_W = 4,
    localparam int unsigned PER_W = DIV_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [PER_W-1:0] period_i,
    output logic [DIV_W-1:0] cnt_o,
    output logic             frame_en_o,
    output logic             frame_end_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    last;

    always_comb begin
        last = (({1'b0, st_q.cnt} + PER_W'(1)) == period_i);
        st_d = st_q;
        if (last) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o       = st_q.cnt;
    assign frame_en_o  = (st_q.cnt == '0);
    assign frame_end_o = last;

    AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ({1'b0, st_q.cnt} < period_i)) else $error("frame counter past period"); // R3

endmodule

// File: rtl/tfclk_clk_shape.sv
module tfclk_clk_shape
    import tfclk_pkg::*;
#(
    parameter int unsigned DIV_W = 4,
    localparam int unsigned PER_W = DIV_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] cnt_i,
    input  logic [PER_W-1:0] period_i,
    input  edge_mode_e       mode_i,
    input  logic             frame_en_i,
    input  logic             frame_end_i,
    output logic             early_o,
    output logic             late_o
);

    typedef struct packed {
        logic lvl;
    } shp_st_t;

    shp_st_t st_d, st_q;
    logic [PER_W-1:0] slot_early, slot_late;
    logic past_mid_early, past_mid_late;

    always_comb begin
        // Half-cycle slot numbers of the current CPU cycle within the frame.
        slot_early     = {cnt_i, 1'b0};
        slot_late      = {cnt_i, 1'b1};
        past_mid_early = (slot_early >= period_i);
        past_mid_late  = (slot_late >= period_i);
        if (mode_i == EDGE_DUAL) begin
            early_o = st_q.lvl ^ past_mid_early;
            late_o  = st_q.lvl ^ past_mid_late;
        end else begin
            early_o = past_mid_early;
            late_o  = past_mid_late;
        end
        st_d = st_q;
        if (frame_end_i) begin
            st_d.lvl = late_o;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{lvl: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    AST_SDR_STARTS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == EDGE_SINGLE && frame_en_i) |-> !early_o) else $error("single-edge frame not low at start"); // R5
    AST_SDR_ENDS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == EDGE_SINGLE && frame_end_i) |-> late_o) else $error("single-edge frame not high at end"); // R5
    AST_DDR_NO_BOUNDARY_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == EDGE_DUAL && frame_en_i) |-> (early_o == $past(late_o))) else $error("edge at frame boundary"); // R8

endmodule

// File: rtl/tfclk_gen.sv
module tfclk_gen
    import tfclk_pkg::*;
#(
    parameter int unsigned DIV_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_slow_i,
    input  logic [DIV_W-1:0] cfg_div_i,
    input  logic             cfg_ddr_i,
    output logic             frame_en_o,
    output logic             tclk_early_o,
    output logic             tclk_late_o
);

    localparam int unsigned PER_W = DIV_W + 1;

    logic             slow_q;
    logic [DIV_W-1:0] div_q;
    edge_mode_e       mode_q;
    logic [PER_W-1:0] period;
    logic [DIV_W-1:0] cnt;
    logic             frame_en;
    logic             frame_end;

    tfclk_cfg_hold #(.DIV_W(DIV_W)) u_cfg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .slow_i   (cfg_slow_i),
        .div_i    (cfg_div_i),
        .ddr_i    (cfg_ddr_i),
        .load_i   (frame_end),
        .slow_o   (slow_q),
        .div_o    (div_q),
        .mode_o   (mode_q),
        .period_o (period)
    );

    tfclk_frame_cnt #(.DIV_W(DIV_W)) u_cnt (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .period_i    (period),
        .cnt_o       (cnt),
        .frame_en_o  (frame_en),
        .frame_end_o (frame_end)
    );

    tfclk_clk_shape #(.DIV_W(DIV_W)) u_shape (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cnt_i       (cnt),
        .period_i    (period),
        .mode_i      (mode_q),
        .frame_en_i  (frame_en),
        .frame_end_i (frame_end),
        .early_o     (tclk_early_o),
        .late_o      (tclk_late_o)
    );

    assign frame_en_o = frame_en;

    AST_FULL_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !slow_q |-> frame_en) else $error("full rate missed a frame"); // R2
    AST_ZERO_DIV_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slow_q && div_q == '0 && frame_en) |=> !frame_en) else $error("zero divisor not halving"); // R4

endmodule

// File: tb/tfclk_gen_tb_top.sv
module tfclk_gen_tb_top;

    localparam int DIV_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_slow = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic             cfg_ddr = 1'b0;
    logic             frame_en;
    logic             tclk_early;
    logic             tclk_late;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    tfclk_gen #(.DIV_W(DIV_W)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .cfg_slow_i   (cfg_slow),
        .cfg_div_i    (cfg_div),
        .cfg_ddr_i    (cfg_ddr),
        .frame_en_o   (frame_en),
        .tclk_early_o (tclk_early),
        .tclk_late_o  (tclk_late)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    function automatic int exp_period(input bit slow, input int div);
        if (!slow) return 1;
        if (div == 0) return 2;
        return div + 1;
    endfunction

    task automatic set_cfg(input bit slow, input int div, input bit ddr);
        cfg_slow = slow;
        cfg_div  = DIV_W'(div);
        cfg_ddr  = ddr;
    endtask

    // Move to the next negedge at which a frame begins.
    task automatic next_frame();
        @(negedge clk);
        while (!frame_en) @(negedge clk);
    endtask

    // Check nfr frames, starting at a negedge where frame_en is high.
    task automatic check_frames(input bit slow, input int div, input bit ddr, input int nfr, input string preq);
        int p = exp_period(slow, div);
        bit lvl = 1'b0;
        bit prev_lvl = 1'b0;
        bit prev_late = 1'b0;
        string creq = ddr ? "R6" : "R5";
        for (int f = 0; f < nfr; f++) begin
            chk(frame_en == 1'b1, preq, "frame_en at frame start", int'(frame_en), 1);
            lvl = tclk_early;
            if (ddr && f > 0) begin
                chk(tclk_early == prev_late, "R8", "early bit vs previous late bit", int'(tclk_early), int'(prev_late));
                chk(lvl != prev_lvl, "R6", "start level alternates", int'(lvl), int'(~prev_lvl));
            end
            for (int k = 0; k < p; k++) begin
                bit e0 = (2 * k >= p);
                bit e1 = (2 * k + 1 >= p);
                if (ddr) begin
                    e0 = lvl ^ e0;
                    e1 = lvl ^ e1;
                end
                if (k > 0) chk(frame_en == 1'b0, preq, "frame_en inside frame", int'(frame_en), 0);
                chk(tclk_early == e0, creq, "early bit", int'(tclk_early), int'(e0));
                chk(tclk_late == e1, creq, "late bit", int'(tclk_late), int'(e1));
                prev_late = tclk_late;
                @(negedge clk);
            end
            prev_lvl = lvl;
        end
        chk(frame_en == 1'b1, preq, "frame_en after last frame", int'(frame_en), 1);
    endtask

    task automatic run_mode(input bit slow, input int div, input bit ddr, input int nfr, input string preq);
        set_cfg(slow, div, ddr);
        repeat (3) next_frame();
        check_frames(slow, div, ddr, nfr, preq);
    endtask

    task automatic test_reset();
        // R1: values while reset is held
        chk(frame_en == 1'b1, "R1", "frame_en in reset", int'(frame_en), 1);
        chk(tclk_early == 1'b0, "R1", "early bit in reset", int'(tclk_early), 0);
        chk(tclk_late == 1'b1, "R1", "late bit in reset", int'(tclk_late), 1);
        set_cfg(1'b0, 0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(frame_en == 1'b1, "R1", "frame_en after reset", int'(frame_en), 1);
        chk(tclk_early == 1'b0 && tclk_late == 1'b1, "R1", "clock bits after reset",
            int'({tclk_early, tclk_late}), 1);
    endtask

    task automatic test_full_rate();
        // R2: divisor has no effect while slow rate is off
        run_mode(1'b0, 9, 1'b0, 4, "R2");
        run_mode(1'b0, 15, 1'b1, 4, "R2");
    endtask

    task automatic test_zero_div();
        // R4: zero divisor halves the rate
        run_mode(1'b1, 0, 1'b0, 3, "R4");
        run_mode(1'b1, 0, 1'b1, 3, "R4");
    endtask

    task automatic test_divided_sdr();
        // R3 and R5: frame lengths N+1 with a mid-frame rising edge
        run_mode(1'b1, 1, 1'b0, 3, "R3");
        run_mode(1'b1, 2, 1'b0, 3, "R3");
        run_mode(1'b1, 5, 1'b0, 3, "R3");
        run_mode(1'b1, 15, 1'b0, 2, "R3");
    endtask

    task automatic test_divided_ddr();
        // R3 and R6: dual-edge waveforms at odd and even periods
        run_mode(1'b1, 2, 1'b1, 4, "R3");
        run_mode(1'b1, 7, 1'b1, 4, "R3");
        run_mode(1'b1, 12, 1'b1, 3, "R3");
    endtask

    task automatic test_midframe_change();
        int len;
        // R7: a divisor change inside a frame waits for the boundary
        set_cfg(1'b1, 7, 1'b0);
        repeat (3) next_frame();
        @(negedge clk);
        @(negedge clk);
        set_cfg(1'b1, 3, 1'b0);
        len = 2;
        while (!frame_en) begin
            @(negedge clk);
            len++;
        end
        chk(len == 8, "R7", "length of frame in progress", len, 8);
        check_frames(1'b1, 3, 1'b0, 2, "R7");
        // R7: slow-rate disable inside a frame waits for the boundary
        @(negedge clk);
        set_cfg(1'b0, 3, 1'b0);
        len = 1;
        while (!frame_en) begin
            @(negedge clk);
            len++;
        end
        chk(len == 4, "R7", "length with slow rate dropped mid-frame", len, 4);
        check_frames(1'b0, 3, 1'b0, 3, "R7");
    endtask

    task automatic test_enter_ddr();
        // R8: switching to dual-edge mid-frame keeps the frame single-edge
        set_cfg(1'b1, 3, 1'b0);
        repeat (3) next_frame();
        @(negedge clk);
        set_cfg(1'b1, 3, 1'b1);
        for (int k = 1; k < 4; k++) begin
            bit e0 = (2 * k >= 4);
            bit e1 = (2 * k + 1 >= 4);
            chk(tclk_early == e0 && tclk_late == e1, "R7", "old-mode waveform kept",
                int'({tclk_early, tclk_late}), int'({e0, e1}));
            @(negedge clk);
        end
        chk(frame_en == 1'b1, "R7", "frame boundary after switch", int'(frame_en), 1);
        chk(tclk_early == 1'b1, "R8", "first dual-edge frame starts high", int'(tclk_early), 1);
        check_frames(1'b1, 3, 1'b1, 3, "R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        test_full_rate();
        test_zero_div();
        test_divided_sdr();
        test_divided_ddr();
        test_midframe_change();
        test_enter_ddr();
        report();
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

endmodule